// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. The segment is moved up by four bit positions and the offset is added to it. Any carry above the top address bit is dropped, so the result always stays inside a 1 MB space. For a near reference, the access class decides which of four segment registers is used. For a far reference, the caller supplies the segment itself.

The block also forms the address for word-sized stack accesses. A push or pop strobe produces a stack-segment address and a new stack pointer. The stack grows toward lower addresses, and the pointer moves by two bytes per access. The caller holds the pointer and feeds it in on `sp_in`. It takes the new value back from `sp_out` and writes it into its own stack pointer register.

Every result appears one clock after the request, together with a valid strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: `addr_out` equals (segment × 16 + offset) modulo 2^20. For example, FFFFh:FFFFh gives 0FFEFh.
- R2: A near request (`req_valid`=1, `far_sel`=0, no stack strobe) selects its segment from `acc_class`: 0 selects `seg_data`, 1 selects `seg_code`, 2 selects `seg_stack` and 3 selects `seg_extra`.
- R3: A far request (`far_sel`=1) uses `far_seg` as the segment, whatever the value of `acc_class`.
- R4: Segment A000h with offset 5677h produces A5677h. Segment A111h with offset 4567h produces the same A5677h.
- R5: On a push, `sp_out` equals (`sp_in` − 2) mod 2^16, and `addr_out` is formed from `seg_stack` and that decremented pointer.
- R6: On a pop, `addr_out` is formed from `seg_stack` and `sp_in`, and `sp_out` equals (`sp_in` + 2) mod 2^16.
- R7: A stack strobe takes priority over `req_valid`, and `far_sel`, `far_seg`, `offset` and `acc_class` are then ignored. If both strobes are high, the push is carried out and the pop is ignored.
- R8: `addr_valid` is high exactly one cycle after a cycle in which `req_valid`, `push_req` or `pop_req` was high, and `addr_out` is updated only in that case. With no stack strobe, `sp_out` equals the `sp_in` of the previous cycle.
- R9: While `rst_n` is low, `addr_valid`, `addr_out` and `sp_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request a data, code or far address |
| acc_class | input | 2 | Near access class: 0 data, 1 code, 2 stack, 3 extra |
| far_sel | input | 1 | Use `far_seg` instead of a segment register |
| far_seg | input | 16 | Explicit segment for far requests |
| offset | input | 16 | Byte offset within the segment |
| seg_data | input | 16 | Data segment register value |
| seg_code | input | 16 | Code segment register value |
| seg_stack | input | 16 | Stack segment register value |
| seg_extra | input | 16 | Extra segment register value |
| sp_in | input | 16 | Current stack pointer |
| push_req | input | 1 | Word push strobe |
| pop_req | input | 1 | Word pop strobe |
| addr_valid | output | 1 | Address result valid |
| addr_out | output | 20 | Physical address |
| sp_out | output | 16 | Updated stack pointer |

## Verification
The assertions assume that `sp_in` and the segment inputs are steady on the clock edge that samples a request, and that nothing else constrains them. In particular, a push and a pop may arrive in the same cycle, and `req_valid` may be high together with a stack strobe. The bench drives every input on the falling edge. It draws segments, offsets and pointers freely over the whole 16-bit range, so carries out of bit 19 and pointer wraps occur naturally. It sets strobe overlap at a low rate so that it still shows up. Directed cases add the two aliasing pairs, the largest address, and pointers at 0000h and FFFEh.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  // Near access class encoding; the value is decoded by seg_select.
  typedef enum logic [1:0] {
    ACC_DATA  = 2'd0,
    ACC_CODE  = 2'd1,
    ACC_STACK = 2'd2,
    ACC_EXTRA = 2'd3
  } acc_class_e;

  // Which path produced the current address.
  typedef enum logic [1:0] {
    SRC_NEAR = 2'd0,
    SRC_FAR  = 2'd1,
    SRC_PUSH = 2'd2,
    SRC_POP  = 2'd3
  } addr_src_e;

endpackage

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  acc_class_e       cls,
  input  logic             far_sel,
  input  logic [SEG_W-1:0] far_seg,
  input  logic [SEG_W-1:0] seg_data,
  input  logic [SEG_W-1:0] seg_code,
  input  logic [SEG_W-1:0] seg_stack,
  input  logic [SEG_W-1:0] seg_extra,
  input  logic             stack_op,
  output logic [SEG_W-1:0] seg_sel,
  output logic             far_used
);

  // A stack operation always uses the stack segment; far is ignored then.
  assign far_used = far_sel && !stack_op;

  always_comb begin
    if (stack_op) begin
      seg_sel = seg_stack;
    end else if (far_sel) begin
      seg_sel = far_seg;
    end else begin
      unique case (cls)
        ACC_DATA:  seg_sel = seg_data;
        ACC_CODE:  seg_sel = seg_code;
        ACC_STACK: seg_sel = seg_stack;
        ACC_EXTRA: seg_sel = seg_extra;
        default:   seg_sel = seg_data;
      endcase
    end
  end

endmodule

// File: rtl/stack_adjust.sv
module stack_adjust #(
  parameter int OFF_W      = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic [OFF_W-1:0] sp_in,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             stack_op,
  output logic             push_win,
  output logic [OFF_W-1:0] stk_off,
  output logic [OFF_W-1:0] sp_next
);

  localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

  // Pointer arithmetic is modulo 2^OFF_W by the width of the result.
  function automatic logic [OFF_W-1:0] sp_step(input logic [OFF_W-1:0] sp,
                                               input logic dec);
    return dec ? (sp - STEP) : (sp + STEP);
  endfunction

  assign stack_op = push_req || pop_req;
  assign push_win = push_req;          // push wins over a concurrent pop

  always_comb begin
    if (push_win) begin
      sp_next = sp_step(sp_in, 1'b1);
      stk_off = sp_next;               // pre-decrement, then address
    end else if (pop_req) begin
      sp_next = sp_step(sp_in, 1'b0);
      stk_off = sp_in;                 // address first, then increment
    end else begin
      sp_next = sp_in;
      stk_off = sp_in;
    end
  end

endmodule

// File: rtl/addr_form.sv
module addr_form #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);

  // Carry beyond ADDR_W is dropped: addresses wrap inside the space.
  function automatic logic [ADDR_W-1:0] form_addr(input logic [SEG_W-1:0] s,
                                                  input logic [OFF_W-1:0] o);
    logic [ADDR_W-1:0] base;
    base = {s, {SHIFT{1'b0}}};
    return base + ADDR_W'(o);
  endfunction

  assign phys = form_addr(seg, off);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W      = 16,
  parameter int OFF_W      = 16,
  parameter int SHIFT      = 4,
  parameter int WORD_BYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [1:0]               acc_class,
  input  logic                     far_sel,
  input  logic [SEG_W-1:0]         far_seg,
  input  logic [OFF_W-1:0]         offset,
  input  logic [SEG_W-1:0]         seg_data,
  input  logic [SEG_W-1:0]         seg_code,
  input  logic [SEG_W-1:0]         seg_stack,
  input  logic [SEG_W-1:0]         seg_extra,
  input  logic [OFF_W-1:0]         sp_in,
  input  logic                     push_req,
  input  logic                     pop_req,
  output logic                     addr_valid,
  output logic [SEG_W+SHIFT-1:0]   addr_out,
  output logic [OFF_W-1:0]         sp_out
);

  localparam int ADDR_W = SEG_W + SHIFT;

  // Named internal events, also used by the checker.
  logic              stack_op;
  logic              push_win;
  logic              far_used;
  logic              issue;
  logic [OFF_W-1:0]  stk_off;
  logic [OFF_W-1:0]  sp_next;
  logic [SEG_W-1:0]  seg_sel;
  logic [OFF_W-1:0]  off_sel;
  logic [ADDR_W-1:0] phys_w;
  addr_src_e         src;

  stack_adjust #(.OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)) stk_i (
    .sp_in    (sp_in),
    .push_req (push_req),
    .pop_req  (pop_req),
    .stack_op (stack_op),
    .push_win (push_win),
    .stk_off  (stk_off),
    .sp_next  (sp_next)
  );

  seg_select #(.SEG_W(SEG_W)) sel_i (
    .cls       (acc_class_e'(acc_class)),
    .far_sel   (far_sel),
    .far_seg   (far_seg),
    .seg_data  (seg_data),
    .seg_code  (seg_code),
    .seg_stack (seg_stack),
    .seg_extra (seg_extra),
    .stack_op  (stack_op),
    .seg_sel   (seg_sel),
    .far_used  (far_used)
  );

  always_comb begin
    if (push_win)      src = SRC_PUSH;
    else if (pop_req)  src = SRC_POP;
    else if (far_sel)  src = SRC_FAR;
    else               src = SRC_NEAR;
  end

  assign off_sel = (src == SRC_PUSH || src == SRC_POP) ? stk_off : offset;
  assign issue   = req_valid || stack_op;

  addr_form #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) form_i (
    .seg  (seg_sel),
    .off  (off_sel),
    .phys (phys_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
      sp_out     <= '0;
    end else begin
      addr_valid <= issue;
      if (issue) addr_out <= phys_w;
      sp_out <= sp_next;
    end
  end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W      = 16,
  parameter int OFF_W      = 16,
  parameter int SHIFT      = 4,
  parameter int WORD_BYTES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [1:0]             acc_class,
  input logic                   far_sel,
  input logic [SEG_W-1:0]       far_seg,
  input logic [OFF_W-1:0]       offset,
  input logic [SEG_W-1:0]       seg_data,
  input logic [SEG_W-1:0]       seg_stack,
  input logic [OFF_W-1:0]       sp_in,
  input logic                   push_req,
  input logic                   pop_req,
  input logic                   addr_valid,
  input logic [SEG_W+SHIFT-1:0] addr_out,
  input logic [OFF_W-1:0]       sp_out,
  input logic                   stack_op,
  input logic                   far_used
);

  localparam int AW = SEG_W + SHIFT;

  function automatic logic [AW-1:0] ref_addr(input logic [SEG_W-1:0] s,
                                             input logic [OFF_W-1:0] o);
    logic [AW:0] wide;
    wide = (AW+1)'(s) * (AW+1)'(1 << SHIFT) + (AW+1)'(o);
    return wide[AW-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] sp_move(input logic [OFF_W-1:0] sp,
                                               input int delta);
    return OFF_W'(int'(sp) + delta);
  endfunction

  logic any_req;
  assign any_req = req_valid || push_req || pop_req;

  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!addr_valid && addr_out == '0 && sp_out == '0));

  a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> addr_valid);

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !addr_valid);

  a_r8_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pop_req) |=> sp_out == $past(sp_in));

  a_r5_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> sp_out == sp_move($past(sp_in), -WORD_BYTES));

  a_r5_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> addr_out == ref_addr($past(seg_stack), sp_move($past(sp_in), -WORD_BYTES)));

  a_r6_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req) |=> sp_out == sp_move($past(sp_in), WORD_BYTES));

  a_r6_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req) |=> addr_out == ref_addr($past(seg_stack), $past(sp_in)));

  a_r3_far_segment: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && far_sel && !push_req && !pop_req) |=>
      addr_out == ref_addr($past(far_seg), $past(offset)));

  a_r2_data_segment: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !far_sel && !push_req && !pop_req && acc_class == 2'd0) |=>
      addr_out == ref_addr($past(seg_data), $past(offset)));

  a_r7_stack_blocks_far: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req) |-> (stack_op && !far_used));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .WORD_BYTES(WORD_BYTES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .acc_class  (acc_class),
  .far_sel    (far_sel),
  .far_seg    (far_seg),
  .offset     (offset),
  .seg_data   (seg_data),
  .seg_stack  (seg_stack),
  .sp_in      (sp_in),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .addr_valid (addr_valid),
  .addr_out   (addr_out),
  .sp_out     (sp_out),
  .stack_op   (stack_op),
  .far_used   (far_used)
);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, far_sel, push_req, pop_req;
  logic [1:0]  acc_class;
  logic [15:0] far_seg, offset, seg_data, seg_code, seg_stack, seg_extra, sp_in;
  logic        addr_valid;
  logic [19:0] addr_out;
  logic [15:0] sp_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_class(acc_class),
    .far_sel(far_sel), .far_seg(far_seg), .offset(offset),
    .seg_data(seg_data), .seg_code(seg_code), .seg_stack(seg_stack),
    .seg_extra(seg_extra), .sp_in(sp_in), .push_req(push_req),
    .pop_req(pop_req), .addr_valid(addr_valid), .addr_out(addr_out),
    .sp_out(sp_out)
  );

  // Bench-side reference: multiply-and-mask rather than shift-and-truncate.
  function automatic int calc_phys(input int seg, input int off);
    return (seg * 16 + off) % 1048576;
  endfunction

  function automatic int wrap16(input int v);
    return (v + 65536) % 65536;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle on the falling edge, then check one edge later.
  task automatic step(input string req, input logic rv, input logic [1:0] cls,
                      input logic fs, input logic [15:0] fseg, input logic [15:0] off,
                      input logic [15:0] sp, input logic pu, input logic po);
    int  seg_e, addr_e, sp_e;
    logic val_e;
    @(negedge clk);
    req_valid = rv; acc_class = cls; far_sel = fs; far_seg = fseg;
    offset = off; sp_in = sp; push_req = pu; pop_req = po;
    sp_e = int'(sp); val_e = 1'b1; addr_e = 0;
    if (pu) begin
      sp_e   = wrap16(int'(sp) - 2);
      addr_e = calc_phys(int'(seg_stack), sp_e);
    end else if (po) begin
      addr_e = calc_phys(int'(seg_stack), int'(sp));
      sp_e   = wrap16(int'(sp) + 2);
    end else if (rv) begin
      if (fs) seg_e = int'(fseg);
      else case (cls)
        2'd0: seg_e = int'(seg_data);
        2'd1: seg_e = int'(seg_code);
        2'd2: seg_e = int'(seg_stack);
        default: seg_e = int'(seg_extra);
      endcase
      addr_e = calc_phys(seg_e, int'(off));
    end else begin
      val_e = 1'b0;
    end
    @(posedge clk);
    #1;
    check(req, int'(addr_valid), int'(val_e), "addr_valid");
    if (val_e) check(req, int'(addr_out), addr_e, "addr_out");
    check(req, int'(sp_out), sp_e, "sp_out");
  endtask

  task automatic run_all();
    logic [19:0] held;
    rst_n = 1'b0;
    req_valid = 0; far_sel = 0; push_req = 0; pop_req = 0; acc_class = 0;
    far_seg = 16'h1234; offset = 16'h5678; sp_in = 16'h0100;
    seg_data = 16'h1000; seg_code = 16'h2000; seg_stack = 16'h3000; seg_extra = 16'h4000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", int'(addr_valid), 0, "reset valid");
    check("R9", int'(addr_out), 0, "reset addr");
    check("R9", int'(sp_out), 0, "reset sp");
    rst_n = 1'b1;

    // R4 aliasing pair
    seg_data = 16'hA000;
    step("R4", 1, 2'd0, 0, 16'h0, 16'h5677, 16'h0100, 0, 0);
    check("R4", int'(addr_out), 'hA5677, "A000:5677");
    step("R4", 1, 2'd0, 1, 16'hA111, 16'h4567, 16'h0100, 0, 0);
    check("R4", int'(addr_out), 'hA5677, "A111:4567");
    // R1 wrap at top of space
    step("R1", 1, 2'd1, 1, 16'hFFFF, 16'hFFFF, 16'h0100, 0, 0);
    check("R1", int'(addr_out), 'h0FFEF, "FFFF:FFFF wraps");
    // R2 each class
    seg_data = 16'h1111; seg_code = 16'h2222; seg_stack = 16'h3333; seg_extra = 16'h4444;
    for (int c = 0; c < 4; c++) step("R2", 1, 2'(c), 0, 16'h9999, 16'h0042, 16'h0200, 0, 0);
    // R3 far ignores class
    step("R3", 1, 2'd3, 1, 16'h7777, 16'h0010, 16'h0200, 0, 0);
    // R5 push at 0000 wraps to FFFE
    step("R5", 0, 2'd0, 0, 16'h0, 16'h0, 16'h0000, 1, 0);
    check("R5", int'(sp_out), 'hFFFE, "push wrap sp");
    // R6 pop at FFFE wraps to 0000
    step("R6", 0, 2'd0, 0, 16'h0, 16'h0, 16'hFFFE, 0, 1);
    check("R6", int'(sp_out), 'h0000, "pop wrap sp");
    // R7 push wins, far and offset ignored
    step("R7", 1, 2'd1, 1, 16'hBEEF, 16'hCAFE, 16'h0400, 1, 1);
    check("R7", int'(sp_out), 'h03FE, "push over pop");
    step("R7", 1, 2'd3, 1, 16'hBEEF, 16'hCAFE, 16'h0400, 0, 1);
    check("R7", int'(addr_out), calc_phys('h3333, 'h0400), "pop ignores far");
    // R8 idle holds address, sp follows input
    held = addr_out;
    step("R8", 0, 2'd0, 1, 16'hFFFF, 16'hFFFF, 16'h1234, 0, 0);
    check("R8", int'(addr_out), int'(held), "addr held when idle");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic rv, fs, pu, po;
      seg_data  = 16'($urandom); seg_code  = 16'($urandom);
      seg_stack = 16'($urandom); seg_extra = 16'($urandom);
      rv = ($urandom % 4) != 0;
      fs = ($urandom % 4) == 0;
      pu = ($urandom % 8) == 0;
      po = ($urandom % 8) == 0;
      step("R1", rv, 2'($urandom), fs, 16'($urandom), 16'($urandom),
           16'($urandom), pu, po);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule